// File: doc/BRIEF.md
# Framed Receive Packet Queue

This block holds received link-layer packets for a consumer that reads them one 33-bit entry at a time. Every entry carries a marker bit above the 32-bit quadlet. A marker of 1 identifies a framing word, the token, and a marker of 0 identifies an ordinary quadlet of packet content. Each accepted packet takes up one token followed by its content quadlets. The token records three things: how many quadlets follow it, the acknowledge code that was returned to the sender, and the speed at which the packet arrived.

Header and payload CRC quadlets have already been checked upstream. They arrive flagged on the write side, and the block discards them. While a packet is arriving, its quadlets are placed in storage behind a slot held back for the token. Nothing of the packet becomes visible to the reader until the end-of-packet beat. On that beat the token is written into the held slot and the whole packet is committed at once. If the queue cannot hold the token and all of the content quadlets, the whole packet is discarded and an overflow pulse is raised.

The read side works in show-ahead fashion: the head entry is always present on the read port. A status word mirrors the marker bit of the head entry, so the consumer can tell a token from content before it pops the entry.

Top module: `rxq_tokfifo`

## Requirements
- R1: A token entry has bit 32 = 1, bits 29:16 = number of content quadlets that follow it, bits 12:8 = acknowledge field (bit 12 = in_ack[4], where 1 marks an error acknowledge, and bits 11:8 = in_ack[3:0]), and bits 5:4 = speed code (00 = 100 Mb/s, 01 = 200 Mb/s, 10 = 400 Mb/s). All other bits are 0.
- R2: A content entry has bit 32 = 0 and bits 31:0 equal to the stored quadlet. Content entries are read in arrival order, directly after their own token.
- R3: A packet's entries do not count toward occupancy before its end-of-packet beat. In the cycle after that beat, occupancy has grown by 1 plus the number of content quadlets.
- R4: A write beat with in_crc = 1 is neither stored nor counted in the token.
- R5: status_o bit 16 equals the marker bit of the head entry, and is 0 when the queue is empty. status_o bits [AW:0] hold the occupancy. All other status bits are 0.
- R6: If occupancy + 1 + content quadlets would exceed DEPTH, nothing of that packet is stored, occupancy is unchanged, and ovf_o is high for exactly the cycle after the end-of-packet beat.
- R7: occ_o gives the number of committed entries and never exceeds DEPTH. full_o = 1 exactly when occ_o = DEPTH. empty_o = 1 exactly when occ_o = 0.
- R8: rd_en removes the head entry, taking effect in the next cycle. rd_en while the queue is empty changes nothing, and rd_data reads 0 while the queue is empty.
- R9: When in_eop and in_valid are both high in the same cycle, the end-of-packet beat is taken and the quadlet is ignored.
- R10: While reset is asserted, and after it is released, the queue is empty with occ_o = 0, ovf_o = 0 and status_o = 0.
- R11: A packet with no content quadlets is stored as a lone token with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Write beat carries a quadlet |
| in_data | input | 32 | Received quadlet |
| in_crc | input | 1 | Quadlet is a checked CRC word and is discarded |
| in_eop | input | 1 | End-of-packet beat; acknowledge and speed are valid |
| in_ack | input | 5 | Bit 4 marks an error acknowledge; bits 3:0 are the acknowledge code |
| in_spd | input | 2 | Receive speed code |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 33 | Head entry (show-ahead), 0 when empty |
| status_o | output | 32 | Bit 16 = head marker; bits [AW:0] = occupancy |
| full_o | output | 1 | Occupancy equals DEPTH |
| empty_o | output | 1 | Occupancy is zero |
| occ_o | output | AW+1 | Committed entries |
| ovf_o | output | 1 | One-cycle pulse when a packet was discarded for lack of room |

## Verification
The bench sweeps packet lengths from zero up to one more than the queue can hold, with CRC beats mixed into each packet. A design that counted CRC beats, or that wrote the token after the content instead of in the held slot, would read back a wrong count or a wrong order. Mixed fills aim at the exact-fit boundary and the one-too-many boundary. Getting the room check off by one would either discard a packet that fits or overwrite unread entries of an earlier packet. Popping an empty queue and raising in_eop together with in_valid catch a design that lets its read pointer wander or that stores the quadlet on the end-of-packet beat.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned QW    = 32;
  localparam int unsigned EW    = QW + 1;
  localparam int unsigned CNT_W = 14;
  localparam int unsigned ACK_W = 5;
  localparam int unsigned SPD_W = 2;

  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic [ACK_W-1:0] ack;
    logic [SPD_W-1:0] spd;
  } tok_fields_t;

  // Token layout: marker at 32, count at 29:16, ack at 12:8, speed at 5:4.
  function automatic logic [EW-1:0] make_token(input tok_fields_t f);
    logic [EW-1:0] t;
    t        = '0;
    t[32]    = 1'b1;
    t[29:16] = f.cnt;
    t[12:8]  = f.ack;
    t[5:4]   = f.spd;
    return t;
  endfunction
endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s = sync_q[STAGES-1];
endmodule

// File: rtl/rxq_stage.sv
module rxq_stage
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned OCC_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst_s,
  input  logic              in_valid,
  input  logic [QW-1:0]     in_data,
  input  logic              in_crc,
  input  logic              in_eop,
  input  logic [ACK_W-1:0]  in_ack,
  input  logic [SPD_W-1:0]  in_spd,
  input  logic [OCC_W-1:0]  used_i,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_off_o,
  output logic [EW-1:0]     wr_word_o,
  output logic              commit_o,
  output logic [OCC_W-1:0]  commit_len_o,
  output logic              ovf_o
);
  localparam int unsigned SUM_W = OCC_W + 1;

  logic [OCC_W-1:0] n_q, n_d;
  logic             drop_q, drop_d;
  logic             ovf_q, ovf_d;
  logic [SUM_W-1:0] need_eop, need_dat;
  tok_fields_t      fields;

  always_comb begin
    need_eop     = SUM_W'(used_i) + SUM_W'(n_q) + SUM_W'(1);
    need_dat     = need_eop + SUM_W'(1);
    fields.cnt   = CNT_W'(n_q);
    fields.ack   = in_ack;
    fields.spd   = in_spd;
    n_d          = n_q;
    drop_d       = drop_q;
    ovf_d        = 1'b0;
    wr_en_o      = 1'b0;
    wr_off_o     = '0;
    wr_word_o    = '0;
    commit_o     = 1'b0;
    commit_len_o = '0;
    if (in_eop) begin
      n_d    = '0;
      drop_d = 1'b0;
      if (!drop_q && (need_eop <= SUM_W'(DEPTH))) begin
        wr_en_o      = 1'b1;
        wr_word_o    = make_token(fields);
        commit_o     = 1'b1;
        commit_len_o = n_q + OCC_W'(1);
      end else begin
        ovf_d = 1'b1;
      end
    end else if (in_valid && !in_crc && !drop_q) begin
      if (need_dat <= SUM_W'(DEPTH)) begin
        wr_en_o   = 1'b1;
        wr_off_o  = AW'(n_q + OCC_W'(1));
        wr_word_o = {1'b0, in_data};
        n_d       = n_q + OCC_W'(1);
      end else begin
        drop_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      n_q    <= '0;
      drop_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      n_q    <= n_d;
      drop_q <= drop_d;
      ovf_q  <= ovf_d;
    end
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned OCC_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst_s,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_off,
  input  logic [EW-1:0]     wr_word,
  input  logic              commit,
  input  logic [OCC_W-1:0]  commit_len,
  input  logic              rd_en,
  output logic [EW-1:0]     rd_data_o,
  output logic [OCC_W-1:0]  used_o
);
  logic [EW-1:0]    mem [DEPTH];
  logic [AW-1:0]    head_q, head_d;
  logic [AW-1:0]    tail_q, tail_d;
  logic [OCC_W-1:0] used_q, used_d;
  logic             pop;
  logic [AW-1:0]    wr_addr;

  always_comb begin
    pop     = rd_en && (used_q != '0);
    wr_addr = tail_q + wr_off;
    head_d  = pop ? head_q + AW'(1) : head_q;
    tail_d  = commit ? tail_q + AW'(commit_len) : tail_q;
    used_d  = used_q - (pop ? OCC_W'(1) : '0) + (commit ? commit_len : '0);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      head_q <= '0;
      tail_q <= '0;
      used_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      used_q <= used_d;
    end
  end

  assign rd_data_o = (used_q == '0) ? '0 : mem[head_q];
  assign used_o    = used_q;
endmodule

// File: rtl/rxq_tokfifo.sv
module rxq_tokfifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned STAGES = 2,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned OCC_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  input  logic             in_crc,
  input  logic             in_eop,
  input  logic [4:0]       in_ack,
  input  logic [1:0]       in_spd,
  input  logic             rd_en,
  output logic [32:0]      rd_data,
  output logic [31:0]      status_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [AW:0]      occ_o,
  output logic             ovf_o
);
  logic             rst_s;
  logic             wr_en;
  logic [AW-1:0]    wr_off;
  logic [EW-1:0]    wr_word;
  logic             commit;
  logic [OCC_W-1:0] commit_len;
  logic [OCC_W-1:0] used;

  rxq_rst_sync #(.STAGES(STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  rxq_stage #(.DEPTH(DEPTH), .AW(AW), .OCC_W(OCC_W)) u_stage (
    .clk          (clk),
    .rst_s        (rst_s),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_crc       (in_crc),
    .in_eop       (in_eop),
    .in_ack       (in_ack),
    .in_spd       (in_spd),
    .used_i       (used),
    .wr_en_o      (wr_en),
    .wr_off_o     (wr_off),
    .wr_word_o    (wr_word),
    .commit_o     (commit),
    .commit_len_o (commit_len),
    .ovf_o        (ovf_o)
  );

  rxq_store #(.DEPTH(DEPTH), .AW(AW), .OCC_W(OCC_W)) u_store (
    .clk        (clk),
    .rst_s      (rst_s),
    .wr_en      (wr_en),
    .wr_off     (wr_off),
    .wr_word    (wr_word),
    .commit     (commit),
    .commit_len (commit_len),
    .rd_en      (rd_en),
    .rd_data_o  (rd_data),
    .used_o     (used)
  );

  always_comb begin
    status_o         = '0;
    status_o[16]     = rd_data[32];
    status_o[AW:0]   = used;
  end

  assign occ_o   = used;
  assign full_o  = (used == OCC_W'(DEPTH));
  assign empty_o = (used == '0);
endmodule

// File: rtl/rxq_tokfifo_chk.sv
module rxq_tokfifo_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_s,
  input logic          in_valid,
  input logic          in_crc,
  input logic          in_eop,
  input logic          rd_en,
  input logic          wr_en,
  input logic          commit,
  input logic [AW:0]   commit_len,
  input logic [AW:0]   occ_o,
  input logic          empty_o,
  input logic [31:0]   status_o,
  input logic [32:0]   rd_data,
  input logic          ovf_o
);
  // R3
  occ_step_chk: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (int'(occ_o) == int'($past(occ_o))
                             - ($past(rd_en && !empty_o) ? 1 : 0)
                             + ($past(commit) ? int'($past(commit_len)) : 0)));

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (empty_o && rd_en && !commit) |=> empty_o);

  // R4
  crc_skip_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (in_valid && in_crc && !in_eop) |-> !wr_en);

  // R6
  ovf_nogrow_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ovf_o |-> (occ_o <= $past(occ_o)));

  // R5
  head_token_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (empty_o && commit) |=> (status_o[16] && rd_data[32]));

  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_s)
    int'(occ_o) <= int'(DEPTH));
endmodule

bind rxq_tokfifo rxq_tokfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .in_valid   (in_valid),
  .in_crc     (in_crc),
  .in_eop     (in_eop),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .commit     (commit),
  .commit_len (commit_len),
  .occ_o      (occ_o),
  .empty_o    (empty_o),
  .status_o   (status_o),
  .rd_data    (rd_data),
  .ovf_o      (ovf_o)
);

// File: tb/sim_rxq_tokfifo.sv
`timescale 1ns/1ps
module sim_rxq_tokfifo;
  localparam int DEPTH = 16;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_crc;
  logic        in_eop;
  logic [4:0]  in_ack;
  logic [1:0]  in_spd;
  logic        rd_en;
  logic [32:0] rd_data;
  logic [31:0] status_o;
  logic        full_o;
  logic        empty_o;
  logic [4:0]  occ_o;
  logic        ovf_o;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  rxq_tokfifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_crc(in_crc), .in_eop(in_eop), .in_ack(in_ack), .in_spd(in_spd),
    .rd_en(rd_en), .rd_data(rd_data), .status_o(status_o), .full_o(full_o),
    .empty_o(empty_o), .occ_o(occ_o), .ovf_o(ovf_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] tok(input int cnt, input logic [4:0] ack, input logic [1:0] spd);
    return {1'b1, 2'b00, 14'(cnt), 3'b000, ack, 2'b00, spd, 4'b0000};
  endfunction

  function automatic logic [31:0] qv(input int base, input int i);
    return 32'hC3A5_0000 ^ 32'(base << 8) ^ 32'(i * 7 + 1);
  endfunction

  task automatic idle();
    in_valid = 0; in_crc = 0; in_eop = 0; rd_en = 0;
  endtask

  task automatic beat_data(input logic [31:0] d, input bit crc);
    in_valid = 1; in_data = d; in_crc = crc;
    @(negedge clk);
    idle();
  endtask

  task automatic beat_eop(input logic [4:0] ack, input logic [1:0] spd);
    in_eop = 1; in_ack = ack; in_spd = spd;
    @(negedge clk);
    idle();
  endtask

  task automatic pop();
    rd_en = 1;
    @(negedge clk);
    idle();
  endtask

  // Writes n content quadlets with CRC beats mixed in, but no end beat.
  task automatic write_body(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      beat_data(qv(base, i), 1'b0);
      if (i == 0) beat_data(32'hFFFF_0000, 1'b1);
    end
    if (n > 0) beat_data(32'h0BAD_C0DE, 1'b1);
  endtask

  task automatic drain_pkt(input int n, input int base, input logic [4:0] ack, input logic [1:0] spd);
    logic [32:0] t;
    t = tok(n, ack, spd);
    check(status_o[16] == 1'b1, "R5 head marker token", status_o[16], 1);
    check(rd_data == t, "R1 R4 R11 token word", rd_data, t);
    pop();
    for (int i = 0; i < n; i++) begin
      check(status_o[16] == 1'b0, "R5 head marker data", status_o[16], 0);
      check(rd_data == {1'b0, qv(base, i)}, "R2 content order", rd_data, {1'b0, qv(base, i)});
      pop();
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_data = '0; in_ack = '0; in_spd = '0;
    idle();
    repeat (3) @(negedge clk);
    // R10 during reset
    check(empty_o && occ_o == 0 && status_o == 0 && !ovf_o, "R10 in reset",
          {empty_o, occ_o, ovf_o}, {1'b1, 5'd0, 1'b0});
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(empty_o && occ_o == 0 && status_o == 0 && !ovf_o && rd_data == 0, "R10 after release",
          {status_o, occ_o}, 0);

    // Length sweep on an empty queue, including zero and one past capacity.
    for (int n = 0; n <= DEPTH; n++) begin
      logic [4:0] ack;
      logic [1:0] spd;
      ack = (n % 2 == 1) ? (5'h10 | 5'(n)) : 5'(n & 15);
      spd = 2'(n % 3);
      write_body(n, n);
      check(occ_o == 0, "R3 invisible before end", occ_o, 0);
      beat_eop(ack, spd);
      if (n + 1 <= DEPTH) begin
        check(occ_o == 5'(n + 1), "R3 commit occupancy", occ_o, n + 1);
        check(!ovf_o, "R6 no overflow when fits", ovf_o, 0);
        check(full_o == (n + 1 == DEPTH), "R7 full flag", full_o, (n + 1 == DEPTH));
        check(status_o[4:0] == 5'(n + 1) && status_o[31:17] == 0 && status_o[15:5] == 0,
              "R5 status layout", status_o, {16'h0001, 16'(n + 1)});
        drain_pkt(n, n, ack, spd);
        check(empty_o && occ_o == 0, "R7 empty after drain", occ_o, 0);
      end else begin
        check(occ_o == 0 && empty_o, "R6 dropped oversize", occ_o, 0);
        check(ovf_o == 1'b1, "R6 overflow pulse", ovf_o, 1);
        @(negedge clk);
        check(ovf_o == 1'b0, "R6 pulse one cycle", ovf_o, 0);
      end
    end

    // Mixed fill: exact-fit and one-too-many boundaries.
    write_body(5, 40); beat_eop(5'h01, 2'b10);
    check(occ_o == 6, "R3 first packet", occ_o, 6);
    write_body(10, 41); beat_eop(5'h02, 2'b01);
    check(occ_o == 6 && ovf_o, "R6 drop keeps earlier packet", {occ_o, ovf_o}, {5'd6, 1'b1});
    write_body(9, 42); beat_eop(5'h13, 2'b00);
    check(occ_o == 16 && full_o && !ovf_o, "R7 exact fit full", {occ_o, full_o}, {5'd16, 1'b1});
    drain_pkt(5, 40, 5'h01, 2'b10);
    drain_pkt(9, 42, 5'h13, 2'b00);
    check(empty_o, "R2 dropped packet absent", occ_o, 0);

    // Pops on an empty queue.
    pop(); pop();
    check(empty_o && occ_o == 0 && rd_data == 0, "R8 empty pop ignored", occ_o, 0);
    write_body(2, 50); beat_eop(5'h0A, 2'b01);
    check(occ_o == 3, "R8 state intact after empty pop", occ_o, 3);
    drain_pkt(2, 50, 5'h0A, 2'b01);

    // End beat together with a quadlet: quadlet ignored.
    beat_data(qv(60, 0), 1'b0);
    in_valid = 1; in_data = 32'hDEAD_BEEF; in_crc = 0;
    beat_eop(5'h05, 2'b10);
    check(occ_o == 2, "R9 quadlet on end beat ignored", occ_o, 2);
    drain_pkt(1, 60, 5'h05, 2'b10);
    check(empty_o, "R9 nothing extra stored", occ_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule